// File: doc/BRIEF.md
# Jump Target Calculator for a 16-bit Segmented Instruction Stream

This block watches a byte-wide instruction stream, one byte per cycle when `byte_valid` is high, and works out where control goes after a jump. The first byte accepted while the block is idle is treated as an opcode, and the instruction pointer of that byte is sampled from `ip_in` in the same cycle. Relative jumps (short, near and the two-byte conditional forms) add a signed displacement to the address of the byte that follows the whole instruction. The far direct jump loads a new offset and a new segment straight from its four operand bytes. The two register-indirect group forms are only recognised: the block reports that they are indirect, whether they change the segment, and the addressing-mode field of their operand byte.

A conditional jump samples `cond_met` together with its displacement byte. When `cond_met` is low the jump is not taken and the next pointer is the address just past the two-byte instruction. Results are registered. They appear with a one-cycle `done` pulse in the cycle after the last byte is accepted, together with the instruction length and the taken, far and indirect flags, and they hold until the next pulse. Bytes that do not begin a recognised jump leave the block idle.

The controller has nine states. IDLE waits for an opcode. An opcode byte moves it to REL8 (short or conditional), REL16_LO (near), FAR_OFF_LO (far) or MODRM (group opcode), and any other opcode keeps it in IDLE. The near path goes REL16_LO to REL16_HI to IDLE. The far path goes FAR_OFF_LO to FAR_OFF_HI to FAR_SEG_LO to FAR_SEG_HI to IDLE. REL8 and MODRM return to IDLE on their single byte. Each move happens only on a cycle with `byte_valid` high. An asynchronous reset returns the controller to IDLE from any state.

Top module: `jump_target_unit`

## Requirements
- R1: During and after reset, `done`, `next_ip`, `next_cs`, `taken`, `far`, `indirect`, `mod_field` and `length` are all zero, and a partly received instruction is dropped.
- R2: Opcode 0xEB takes one displacement byte. The result is `next_ip` = opcode IP + 2 + the sign-extended byte, with `taken`=1 and `length`=2, whatever the value of `cond_met`.
- R3: Opcode 0xE9 takes a 16-bit displacement, low byte first. The result is `next_ip` = opcode IP + 3 + displacement, with `taken`=1 and `length`=3.
- R4: Opcode 0xEA takes offset low, offset high, segment low and segment high, in that order. The result is `next_ip` = offset and `next_cs` = segment, with `far`=1, `taken`=1 and `length`=5.
- R5: Opcodes with upper nibble 0111 take one displacement byte. When `cond_met` is high in the cycle that byte is accepted, `next_ip` = opcode IP + 2 + the sign-extended byte and `taken`=1.
- R6: When `cond_met` is low in the cycle that byte is accepted, `next_ip` = opcode IP + 2, with `taken`=0, `far`=0 and `length`=2.
- R7: All relative sums wrap modulo 2^16, both forward past 0xFFFF and backward below 0x0000.
- R8: For opcode 0xFF, the following byte has mode field in bits 7:6 and sub-opcode in bits 5:3. Sub-opcode 100 gives `indirect`=1 and `far`=0. Sub-opcode 101 gives `indirect`=1 and `far`=1. Both give `mod_field` = bits 7:6, `length`=2, `taken`=1, `next_ip` = opcode IP and `next_cs`=0.
- R9: Any other opcode, and 0xFF followed by any other sub-opcode, produces no `done` pulse and leaves the block ready for a new opcode in the next cycle.
- R10: `done` is a single-cycle pulse in the cycle after the last byte is accepted, and all results hold until the next pulse. `next_cs` is zero for every result other than the direct far jump.
- R11: `ip_in` is sampled only with an opcode byte, and cycles with `byte_valid` low are ignored in every state, so an instruction may be spread over stall cycles.
- R12: The opcode of the next instruction may be presented in the same cycle that `done` is high for the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| byte_valid | input | 1 | Qualifies `byte_data` in this cycle |
| byte_data | input | 8 | Instruction stream byte |
| ip_in | input | 16 | Instruction pointer of the byte in this cycle, used for opcode bytes |
| cond_met | input | 1 | Branch condition, sampled with a conditional jump's displacement byte |
| done | output | 1 | One-cycle result strobe |
| next_ip | output | 16 | Next instruction pointer |
| next_cs | output | 16 | New code segment for a direct far jump, otherwise zero |
| taken | output | 1 | Control leaves the sequential path |
| far | output | 1 | Segment changes (direct far or indirect far) |
| indirect | output | 1 | Target comes from an operand that this block does not read |
| mod_field | output | 2 | Addressing-mode field of an indirect jump's operand byte |
| length | output | 3 | Number of bytes consumed for the instruction |

## Verification
Two functions can fall in the same cycle: the result strobe of one instruction and the acceptance of the next instruction's opcode, together with the sampling of its IP. The bench presents a short jump and then puts a conditional opcode on the bus in the very cycle the first `done` is high. It checks the first result in that cycle, and it then checks that the second result uses the IP sampled in that same cycle. Stall cycles inside a near jump and an unrecognised opcode placed just before a real jump also check that the controller never mixes bytes across instruction boundaries.

// File: rtl/jtu_pkg.sv
package jtu_pkg;

    localparam int BYTE_W = 8;
    localparam int IP_W   = 2 * BYTE_W;
    localparam int LEN_W  = 3;
    localparam int MOD_W  = 2;

    localparam logic [BYTE_W-1:0] OPC_SHORT = 8'hEB;
    localparam logic [BYTE_W-1:0] OPC_NEAR  = 8'hE9;
    localparam logic [BYTE_W-1:0] OPC_FAR   = 8'hEA;
    localparam logic [BYTE_W-1:0] OPC_GROUP = 8'hFF;
    localparam logic [3:0]        OPC_COND_NIB = 4'b0111;

    localparam logic [2:0] SUB_IND_NEAR = 3'b100;
    localparam logic [2:0] SUB_IND_FAR  = 3'b101;

    localparam logic [LEN_W-1:0] LEN_REL8  = LEN_W'(2);
    localparam logic [LEN_W-1:0] LEN_REL16 = LEN_W'(3);
    localparam logic [LEN_W-1:0] LEN_FAR   = LEN_W'(5);
    localparam logic [LEN_W-1:0] LEN_IND   = LEN_W'(2);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_REL8,
        ST_REL16_LO,
        ST_REL16_HI,
        ST_FAR_OFF_LO,
        ST_FAR_OFF_HI,
        ST_FAR_SEG_LO,
        ST_FAR_SEG_HI,
        ST_MODRM
    } jtu_state_e;

    typedef enum logic [2:0] {
        JK_NONE,
        JK_SHORT,
        JK_COND,
        JK_NEAR,
        JK_FAR,
        JK_GROUP
    } jtu_kind_e;

endpackage

// File: rtl/jtu_opcode_class.sv
module jtu_opcode_class
    import jtu_pkg::*;
(
    input  logic [BYTE_W-1:0] opcode,
    output jtu_kind_e         kind
);
    always_comb begin
        if (opcode == OPC_SHORT)
            kind = JK_SHORT;
        else if (opcode == OPC_NEAR)
            kind = JK_NEAR;
        else if (opcode == OPC_FAR)
            kind = JK_FAR;
        else if (opcode == OPC_GROUP)
            kind = JK_GROUP;
        else if (opcode[BYTE_W-1 -: 4] == OPC_COND_NIB)
            kind = JK_COND;
        else
            kind = JK_NONE;
    end
endmodule

// File: rtl/jtu_modrm_split.sv
module jtu_modrm_split
    import jtu_pkg::*;
(
    input  logic [BYTE_W-1:0] modrm,
    output logic [MOD_W-1:0]  mod_f,
    output logic              ind_near,
    output logic              ind_far
);
    logic [2:0] sub_op;

    assign mod_f    = modrm[7:6];
    assign sub_op   = modrm[5:3];
    assign ind_near = (sub_op == SUB_IND_NEAR);
    assign ind_far  = (sub_op == SUB_IND_FAR);
endmodule

// File: rtl/jtu_target_adder.sv
module jtu_target_adder
    import jtu_pkg::*;
(
    input  logic [IP_W-1:0]  base_ip,
    input  logic [LEN_W-1:0] instr_len,
    input  logic [IP_W-1:0]  disp,
    output logic [IP_W-1:0]  target
);
    logic [IP_W-1:0] len_ext;

    assign len_ext = {{(IP_W-LEN_W){1'b0}}, instr_len};
    assign target  = base_ip + len_ext + disp;
endmodule

// File: rtl/jump_target_unit.sv
module jump_target_unit
    import jtu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic [IP_W-1:0]   ip_in,
    input  logic              cond_met,
    output logic              done,
    output logic [IP_W-1:0]   next_ip,
    output logic [IP_W-1:0]   next_cs,
    output logic              taken,
    output logic              far,
    output logic              indirect,
    output logic [MOD_W-1:0]  mod_field,
    output logic [LEN_W-1:0]  length
);
    jtu_state_e state_q, state_d;
    jtu_kind_e  kind_dec, kind_q;

    logic [IP_W-1:0]   ip_q;
    logic [IP_W-1:0]   off_q;
    logic [BYTE_W-1:0] lo_q;

    logic [MOD_W-1:0]  mrm_mod;
    logic              mrm_near, mrm_far;

    logic [LEN_W-1:0]  add_len;
    logic [IP_W-1:0]   add_disp;
    logic [IP_W-1:0]   add_sum;
    logic [IP_W-1:0]   disp8_ext;
    logic              cond_ok;

    logic              fin;
    logic [IP_W-1:0]   res_ip, res_cs;
    logic              res_taken, res_far, res_ind;
    logic [MOD_W-1:0]  res_mod;
    logic [LEN_W-1:0]  res_len;

    jtu_opcode_class u_class (
        .opcode (byte_data),
        .kind   (kind_dec)
    );

    jtu_modrm_split u_modrm (
        .modrm    (byte_data),
        .mod_f    (mrm_mod),
        .ind_near (mrm_near),
        .ind_far  (mrm_far)
    );

    jtu_target_adder u_adder (
        .base_ip   (ip_q),
        .instr_len (add_len),
        .disp      (add_disp),
        .target    (add_sum)
    );

    assign disp8_ext = {{(IP_W-BYTE_W){byte_data[BYTE_W-1]}}, byte_data};
    assign cond_ok   = (kind_q != JK_COND) || cond_met;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        if (byte_valid) begin
            unique case (state_q)
                ST_IDLE: begin
                    unique case (kind_dec)
                        JK_SHORT, JK_COND: state_d = ST_REL8;
                        JK_NEAR:           state_d = ST_REL16_LO;
                        JK_FAR:            state_d = ST_FAR_OFF_LO;
                        JK_GROUP:          state_d = ST_MODRM;
                        default:           state_d = ST_IDLE;
                    endcase
                end
                ST_REL8:       state_d = ST_IDLE;
                ST_REL16_LO:   state_d = ST_REL16_HI;
                ST_REL16_HI:   state_d = ST_IDLE;
                ST_FAR_OFF_LO: state_d = ST_FAR_OFF_HI;
                ST_FAR_OFF_HI: state_d = ST_FAR_SEG_LO;
                ST_FAR_SEG_LO: state_d = ST_FAR_SEG_HI;
                ST_FAR_SEG_HI: state_d = ST_IDLE;
                ST_MODRM:      state_d = ST_IDLE;
                default:       state_d = ST_IDLE;
            endcase
        end
    end

    // Adder operand selection
    always_comb begin
        add_len  = LEN_REL8;
        add_disp = '0;
        unique case (state_q)
            ST_REL8: begin
                add_len  = LEN_REL8;
                add_disp = cond_ok ? disp8_ext : '0;
            end
            ST_REL16_HI: begin
                add_len  = LEN_REL16;
                add_disp = {byte_data, lo_q};
            end
            default: ;
        endcase
    end

    // Completion and result selection
    always_comb begin
        fin       = 1'b0;
        res_ip    = ip_q;
        res_cs    = '0;
        res_taken = 1'b1;
        res_far   = 1'b0;
        res_ind   = 1'b0;
        res_mod   = '0;
        res_len   = LEN_REL8;
        unique case (state_q)
            ST_REL8: begin
                fin       = byte_valid;
                res_ip    = add_sum;
                res_taken = cond_ok;
                res_len   = LEN_REL8;
            end
            ST_REL16_HI: begin
                fin     = byte_valid;
                res_ip  = add_sum;
                res_len = LEN_REL16;
            end
            ST_FAR_SEG_HI: begin
                fin     = byte_valid;
                res_ip  = off_q;
                res_cs  = {byte_data, lo_q};
                res_far = 1'b1;
                res_len = LEN_FAR;
            end
            ST_MODRM: begin
                fin     = byte_valid && (mrm_near || mrm_far);
                res_ind = 1'b1;
                res_far = mrm_far;
                res_mod = mrm_mod;
                res_len = LEN_IND;
            end
            default: ;
        endcase
    end

    // Operand capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ip_q   <= '0;
            kind_q <= JK_NONE;
            lo_q   <= '0;
            off_q  <= '0;
        end else if (byte_valid) begin
            unique case (state_q)
                ST_IDLE: begin
                    ip_q   <= ip_in;
                    kind_q <= kind_dec;
                end
                ST_REL16_LO, ST_FAR_OFF_LO, ST_FAR_SEG_LO: lo_q <= byte_data;
                ST_FAR_OFF_HI: off_q <= {byte_data, lo_q};
                default: ;
            endcase
        end
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done      <= 1'b0;
            next_ip   <= '0;
            next_cs   <= '0;
            taken     <= 1'b0;
            far       <= 1'b0;
            indirect  <= 1'b0;
            mod_field <= '0;
            length    <= '0;
        end else begin
            done <= fin;
            if (fin) begin
                next_ip   <= res_ip;
                next_cs   <= res_cs;
                taken     <= res_taken;
                far       <= res_far;
                indirect  <= res_ind;
                mod_field <= res_mod;
                length    <= res_len;
            end
        end
    end
endmodule

// File: rtl/jtu_checker.sv
module jtu_checker
    import jtu_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic [IP_W-1:0]   next_ip,
    input logic [IP_W-1:0]   next_cs,
    input logic              taken,
    input logic              far,
    input logic              indirect,
    input logic [LEN_W-1:0]  length
);
    // R10: strobe never lasts two cycles
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: results hold between strobes
    p_hold_ip_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(next_ip));

    // R10: segment is zero outside the direct far jump
    p_cs_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (!far || indirect)) |-> (next_cs == '0));

    // R4: direct far jump is five bytes and taken
    p_far_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && far && !indirect) |-> (length == LEN_FAR && taken));

    // R6: a jump not taken is always the two-byte relative form
    p_not_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !taken) |-> (length == LEN_REL8 && !far && !indirect));

    // R8: indirect forms consume two bytes and are taken
    p_indirect_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && indirect) |-> (length == LEN_IND && taken));
endmodule

bind jump_target_unit jtu_checker u_jtu_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (done),
    .next_ip  (next_ip),
    .next_cs  (next_cs),
    .taken    (taken),
    .far      (far),
    .indirect (indirect),
    .length   (length)
);

// File: tb/jump_target_unit_test.sv
`timescale 1ns/1ps
module jump_target_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic [15:0] ip_in = 16'h0000;
    logic        cond_met = 1'b0;
    logic        done;
    logic [15:0] next_ip, next_cs;
    logic        taken, far, indirect;
    logic [1:0]  mod_field;
    logic [2:0]  length;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    jump_target_unit uut (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
        .ip_in(ip_in), .cond_met(cond_met), .done(done), .next_ip(next_ip),
        .next_cs(next_cs), .taken(taken), .far(far), .indirect(indirect),
        .mod_field(mod_field), .length(length)
    );

    localparam int NV = 11;
    // bytes packed first byte in bits 39:32
    localparam logic [39:0] V_BYTES [NV] = '{
        40'hEB_E6_000000, 40'hE9_F7_02_0000, 40'hEA_94_00_C5_01,
        40'h74_10_000000, 40'h74_10_000000, 40'h7F_80_000000,
        40'hEB_7F_000000, 40'hE9_00_80_0000, 40'hFF_26_000000,
        40'hFF_EB_000000, 40'hEB_05_000000};
    localparam int          V_N    [NV] = '{2, 3, 5, 2, 2, 2, 2, 3, 2, 2, 2};
    localparam logic [15:0] V_IP   [NV] = '{16'h0054, 16'h010C, 16'h1234, 16'h0100,
        16'h0100, 16'h0000, 16'hFFF0, 16'h9000, 16'h2000, 16'h3000, 16'h0010};
    localparam logic        V_COND [NV] = '{0, 0, 0, 1, 0, 1, 0, 0, 0, 0, 1};
    localparam logic [15:0] V_EIP  [NV] = '{16'h003C, 16'h0406, 16'h0094, 16'h0112,
        16'h0102, 16'hFF82, 16'h0071, 16'h1003, 16'h2000, 16'h3000, 16'h0017};
    localparam logic [15:0] V_ECS  [NV] = '{16'h0000, 16'h0000, 16'h01C5, 16'h0000,
        16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000};
    // flags: {taken, far, indirect}
    localparam logic [2:0]  V_FLG  [NV] = '{3'b100, 3'b100, 3'b110, 3'b100, 3'b000,
        3'b100, 3'b100, 3'b100, 3'b101, 3'b111, 3'b100};
    localparam logic [1:0]  V_MOD  [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 3, 0};
    localparam logic [2:0]  V_LEN  [NV] = '{2, 3, 5, 2, 2, 2, 2, 3, 2, 2, 2};
    localparam logic [15:0] V_TAG  [NV] = '{"R2", "R3", "R4", "R5", "R6", "R7",
        "R7", "R7", "R8", "R8", "R2"};

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic put_byte(input logic [7:0] b, input logic [15:0] ip, input logic c);
        @(negedge clk);
        byte_valid = 1'b1;
        byte_data  = b;
        ip_in      = ip;
        cond_met   = c;
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        byte_valid = 1'b0;
        byte_data  = 8'h00;
        ip_in      = 16'hDEAD;
        cond_met   = 1'b0;
    endtask

    task automatic check_result(input string req, input logic [15:0] eip,
                                input logic [15:0] ecs, input logic [2:0] flg,
                                input logic [1:0] emod, input logic [2:0] elen);
        check(req, "done", done, 1);
        check(req, "next_ip", next_ip, eip);
        check(req, "next_cs", next_cs, ecs);
        check(req, "taken", taken, flg[2]);
        check(req, "far", far, flg[1]);
        check(req, "indirect", indirect, flg[0]);
        check(req, "mod_field", mod_field, emod);
        check(req, "length", length, elen);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        check("R1", "done", done, 0);
        check("R1", "next_ip", next_ip, 0);
        check("R1", "next_cs", next_cs, 0);
        check("R1", "flags", {taken, far, indirect}, 0);
        check("R1", "mod/len", {mod_field, length}, 0);
        rst_n = 1'b1;
        idle_cycle();

        // Vector table: non-opcode bytes carry a junk IP and inverted condition (R11)
        for (int i = 0; i < NV; i++) begin
            for (int k = 0; k < V_N[i]; k++) begin
                if (k == 0)
                    put_byte(V_BYTES[i][39 -: 8], V_IP[i], ~V_COND[i]);
                else if (k == V_N[i] - 1)
                    put_byte(V_BYTES[i][39 - 8*k -: 8], 16'hDEAD, V_COND[i]);
                else
                    put_byte(V_BYTES[i][39 - 8*k -: 8], 16'hDEAD, ~V_COND[i]);
            end
            idle_cycle();
            check_result($sformatf("%s", V_TAG[i]), V_EIP[i], V_ECS[i], V_FLG[i],
                         V_MOD[i], V_LEN[i]);
            idle_cycle();
            check("R10", "done pulse", done, 0);
            check("R10", "held next_ip", next_ip, V_EIP[i]);
        end

        // R11: stall cycles inside a near jump
        put_byte(8'hE9, 16'h0000, 1'b0);
        idle_cycle();
        check("R11", "done during stall", done, 0);
        idle_cycle();
        put_byte(8'h00, 16'hDEAD, 1'b0);
        idle_cycle();
        check("R11", "done during stall", done, 0);
        put_byte(8'h01, 16'hDEAD, 1'b0);
        idle_cycle();
        check_result("R11", 16'h0103, 16'h0000, 3'b100, 2'd0, 3'd3);

        // R9: unrecognised opcode is ignored, next byte starts a jump
        put_byte(8'h90, 16'h0400, 1'b0);
        idle_cycle();
        check("R9", "done after 0x90", done, 0);
        put_byte(8'hEB, 16'h0500, 1'b0);
        put_byte(8'h00, 16'hDEAD, 1'b0);
        idle_cycle();
        check_result("R9", 16'h0502, 16'h0000, 3'b100, 2'd0, 3'd2);

        // R9: group opcode with another sub-opcode is dropped
        put_byte(8'hFF, 16'h0600, 1'b0);
        put_byte(8'hC0, 16'hDEAD, 1'b0);
        idle_cycle();
        check("R9", "done after FF /0", done, 0);
        check("R9", "next_ip untouched", next_ip, 16'h0502);
        put_byte(8'hEB, 16'h0680, 1'b0);
        put_byte(8'h02, 16'hDEAD, 1'b0);
        idle_cycle();
        check_result("R9", 16'h0684, 16'h0000, 3'b100, 2'd0, 3'd2);

        // R12: next opcode accepted in the strobe cycle
        put_byte(8'hEB, 16'h0100, 1'b0);
        put_byte(8'h02, 16'hDEAD, 1'b0);
        put_byte(8'h74, 16'h0104, 1'b0);
        check_result("R12", 16'h0104, 16'h0000, 3'b100, 2'd0, 3'd2);
        put_byte(8'h10, 16'hDEAD, 1'b1);
        idle_cycle();
        check_result("R12", 16'h0116, 16'h0000, 3'b100, 2'd0, 3'd2);

        // R1: reset in the middle of a far jump
        put_byte(8'hEA, 16'h0800, 1'b0);
        put_byte(8'h11, 16'hDEAD, 1'b0);
        @(negedge clk);
        byte_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "done in reset", done, 0);
        check("R1", "next_ip in reset", next_ip, 0);
        rst_n = 1'b1;
        put_byte(8'hEB, 16'h0700, 1'b0);
        put_byte(8'h00, 16'hDEAD, 1'b0);
        idle_cycle();
        check_result("R1", 16'h0702, 16'h0000, 3'b100, 2'd0, 3'd2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule